// File: doc/BRIEF.md
# Label-Filtered Serial Word Receive Buffer

This block sits behind an avionics serial receive channel that has already decoded, timed and validated each word. It receives complete 32-bit words together with a one-cycle valid strobe. When label recognition is enabled, the block accepts a word only if its 8-bit label appears in a small table that the host has programmed. Accepted words queue in a first-in first-out buffer. Three status outputs tell the host whether data is waiting, whether the buffer is at least half occupied, and whether it is full.

The host loads the label table by raising a load-mode input and writing labels one after another. It reads stored words over a 16-bit bus, in two transfers per word. A half-select input chooses which half of the head word is driven onto the bus. A read strobe taken while the upper half is selected removes the word from the buffer. A mapping input chooses between driving the word's bits unchanged and reordering the label bits onto the bus.

Top module: `arinc_label_rx_buffer`

## Requirements
- R1: A synchronous active-high reset empties the buffer, drives all three status outputs low and invalidates every label entry, so that after reset no word is accepted while recognition is enabled.
- R2: While `recog_en` is 0, every word presented with `rx_valid` high is stored, provided the buffer is not full.
- R3: While `recog_en` is 1, a word is stored only if its label (word bits 7:0) equals a valid table entry in all 8 bits. A word whose label matches no entry leaves the buffer unchanged.
- R4: Each rising edge of `lbl_load` restarts the table write position at entry 0. Each cycle with `lbl_load` and `lbl_wr` both high writes `lbl_data` into the current entry and advances the position. After entry 15 the position wraps to entry 0, and an earlier label held there no longer matches.
- R5: The buffer holds 32 words of 32 bits and returns them in the order they were accepted.
- R6: A word that arrives while the buffer is full is discarded, and the stored words and their order stay as they were.
- R7: `data_ready` is high when at least 1 word is stored, `half_full` when at least 16 are stored, and `full` when 32 are stored. Each output reflects the occupancy after the clock edge that accepted a push or a pop.
- R8: With `rd_half` = 0, `rd_data` shows bits 15:0 of the head word. With `rd_half` = 1, it shows bits 31:16. A `rd_strobe` cycle removes the head word only when `rd_half` is 1; a strobe with `rd_half` = 0 removes nothing.
- R9: With `remap_en` = 1, bus bits 7:0 of the lower half carry the label in reversed order (bus bit k = word bit 7-k). Every other bus bit is unchanged. With `remap_en` = 0, all bits are driven unchanged.
- R10: A removal strobe while the buffer is empty is ignored: the buffer stays empty, and the next accepted word is read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 32 | Decoded received word, label in bits 7:0 |
| rx_valid | input | 1 | One-cycle strobe marking rx_word valid |
| recog_en | input | 1 | 1 = filter words against the label table |
| remap_en | input | 1 | 1 = reversed label bit order on the bus |
| lbl_load | input | 1 | Label table load mode |
| lbl_wr | input | 1 | Write lbl_data into the next table entry |
| lbl_data | input | 8 | Label value to write |
| rd_half | input | 1 | Half select: 0 = bits 15:0, 1 = bits 31:16 |
| rd_strobe | input | 1 | Host read strobe; removes the head word when rd_half is 1 |
| rd_data | output | 16 | Selected half of the head word |
| data_ready | output | 1 | Buffer holds at least one word |
| half_full | output | 1 | Buffer holds at least 16 words |
| full | output | 1 | Buffer holds 32 words |

## Verification
A word presented with `rx_valid` is written at the next rising edge, and the status outputs show the new occupancy directly after that edge. `rd_data` follows `rd_half` and the head word combinationally within the same cycle. A removal takes effect at the edge on which the strobe is sampled. The bench drives every input on the falling edge. It checks status outputs at the falling edge that follows the push or pop edge, and it checks `rd_data` one time step after changing `rd_half`, before the next rising edge.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned LABEL_W = 8;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [LABEL_W-1:0] label_t;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    typedef enum logic {
        MAP_STRAIGHT = 1'b0,
        MAP_REORDER  = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic   valid;
        label_t code;
    } label_entry_t;

    typedef struct packed {
        logic ready;
        logic half;
        logic full;
    } rx_status_t;

    // Label occupies the lowest bits of the word.
    function automatic label_t label_of(input word_t w);
        return w[LABEL_W-1:0];
    endfunction

    function automatic label_t reverse_label(input label_t l);
        label_t r;
        for (int i = 0; i < int'(LABEL_W); i++) begin
            r[i] = l[LABEL_W-1-i];
        end
        return r;
    endfunction

    // Bus image of a stored word under the selected mapping.
    function automatic word_t bus_image(input word_t w, input map_mode_e m);
        word_t img;
        img = w;
        if (m == MAP_REORDER) begin
            img[LABEL_W-1:0] = reverse_label(label_of(w));
        end
        return img;
    endfunction

    function automatic half_t pick_half(input word_t w, input half_sel_e s);
        return (s == HALF_HI) ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/a429_label_table.sv
module a429_label_table
    import a429_rx_pkg::*;
#(
    parameter int unsigned LBL_COUNT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load_mode,
    input  logic   wr_en,
    input  label_t wr_label,
    input  label_t probe,
    output logic   hit
);

    localparam int unsigned PTR_W = (LBL_COUNT > 1) ? $clog2(LBL_COUNT) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(LBL_COUNT - 1);

    label_entry_t           table_q [LBL_COUNT];
    logic [PTR_W-1:0]       ptr_q;
    logic [PTR_W-1:0]       slot;
    logic                   mode_q;
    logic                   load_start;
    logic                   do_wr;
    logic [LBL_COUNT-1:0]   hit_vec;

    assign load_start = load_mode && !mode_q;
    assign slot       = load_start ? '0 : ptr_q;
    assign do_wr      = load_mode && wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            ptr_q  <= '0;
            for (int i = 0; i < int'(LBL_COUNT); i++) begin
                table_q[i] <= '0;
            end
        end else begin
            mode_q <= load_mode;
            if (do_wr) begin
                table_q[slot] <= '{valid: 1'b1, code: wr_label};
                ptr_q         <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
            end else if (load_start) begin
                ptr_q <= '0;
            end
        end
    end

    for (genvar g = 0; g < int'(LBL_COUNT); g++) begin : g_cmp
        assign hit_vec[g] = table_q[g].valid && (table_q[g].code == probe);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo
    import a429_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push_req,
    input  word_t                          push_word,
    input  logic                           pop_req,
    output word_t                          head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    word_t          mem_q [DEPTH];
    logic [AW-1:0]  wr_ptr_q;
    logic [AW-1:0]  rd_ptr_q;
    logic [CW-1:0]  cnt_q;
    logic           push_ok;
    logic           pop_ok;

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return (a == LAST_ADDR) ? '0 : a + 1'b1;
    endfunction

    // A push is judged against the occupancy at the start of the cycle.
    assign push_ok = push_req && (cnt_q != FULL_CNT);
    assign pop_ok  = pop_req  && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_ptr_q] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= next_addr(wr_ptr_q);
            end
            if (pop_ok) begin
                rd_ptr_q <= next_addr(rd_ptr_q);
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem_q[rd_ptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/a429_host_view.sv
module a429_host_view
    import a429_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  word_t                          head,
    input  logic [$clog2(DEPTH+1)-1:0]     count,
    input  map_mode_e                      map_mode,
    input  half_sel_e                      half_sel,
    output half_t                          bus_out,
    output rx_status_t                     status
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    word_t image;

    always_comb begin
        image   = bus_image(head, map_mode);
        bus_out = pick_half(image, half_sel);
    end

    always_comb begin
        status.ready = (count != '0);
        status.half  = (count >= HALF_CNT);
        status.full  = (count == FULL_CNT);
    end

endmodule

// File: rtl/arinc_label_rx_buffer.sv
module arinc_label_rx_buffer
    import a429_rx_pkg::*;
#(
    parameter int unsigned LBL_COUNT  = 16,
    parameter int unsigned FIFO_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] rx_word,
    input  logic        rx_valid,
    input  logic        recog_en,
    input  logic        remap_en,
    input  logic        lbl_load,
    input  logic        lbl_wr,
    input  logic [7:0]  lbl_data,
    input  logic        rd_half,
    input  logic        rd_strobe,
    output logic [15:0] rd_data,
    output logic        data_ready,
    output logic        half_full,
    output logic        full
);

    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    logic            lbl_hit;
    logic            push_req;
    logic            pop_req;
    word_t           head_word;
    logic [CW-1:0]   fifo_count;
    rx_status_t      stat;
    half_t           bus_half;
    map_mode_e       map_mode;
    half_sel_e       half_sel;

    assign map_mode = remap_en ? MAP_REORDER : MAP_STRAIGHT;
    assign half_sel = rd_half  ? HALF_HI     : HALF_LO;

    a429_label_table #(
        .LBL_COUNT (LBL_COUNT)
    ) u_labels (
        .clk       (clk),
        .rst       (rst),
        .load_mode (lbl_load),
        .wr_en     (lbl_wr),
        .wr_label  (lbl_data),
        .probe     (label_of(rx_word)),
        .hit       (lbl_hit)
    );

    assign push_req = rx_valid && (!recog_en || lbl_hit);
    assign pop_req  = rd_strobe && (half_sel == HALF_HI);

    a429_word_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .push_word (rx_word),
        .pop_req   (pop_req),
        .head      (head_word),
        .count     (fifo_count)
    );

    a429_host_view #(
        .DEPTH (FIFO_DEPTH)
    ) u_view (
        .head     (head_word),
        .count    (fifo_count),
        .map_mode (map_mode),
        .half_sel (half_sel),
        .bus_out  (bus_half),
        .status   (stat)
    );

    assign rd_data    = bus_half;
    assign data_ready = stat.ready;
    assign half_full  = stat.half;
    assign full       = stat.full;

endmodule

// File: rtl/arinc_label_rx_buffer_chk.sv
module arinc_label_rx_buffer_chk #(
    parameter int unsigned DEPTH = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        rx_valid,
    input logic                        recog_en,
    input logic                        rd_strobe,
    input logic                        rd_half,
    input logic                        data_ready,
    input logic                        half_full,
    input logic                        full,
    input logic                        lbl_hit,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_count
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!data_ready && !half_full && !full)); // R1

    AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (rst)
        (full |-> half_full) and (half_full |-> data_ready)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && !(rd_strobe && rd_half)) |=> (full && $stable(fifo_count))); // R6

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (recog_en && rx_valid && !lbl_hit && !(rd_strobe && rd_half)) |=> $stable(fifo_count)); // R3

    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (data_ready && rd_strobe && rd_half && !rx_valid) |=> (fifo_count == $past(fifo_count) - CW'(1))); // R8

    AST_LOWER_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !rd_half && !rx_valid) |=> $stable(fifo_count)); // R8

    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!data_ready && rd_strobe && rd_half && !rx_valid) |=> !data_ready); // R10

endmodule

bind arinc_label_rx_buffer arinc_label_rx_buffer_chk #(
    .DEPTH (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .recog_en   (recog_en),
    .rd_strobe  (rd_strobe),
    .rd_half    (rd_half),
    .data_ready (data_ready),
    .half_full  (half_full),
    .full       (full),
    .lbl_hit    (lbl_hit),
    .fifo_count (fifo_count)
);

// File: tb/arinc_label_rx_buffer_tb_top.sv
module arinc_label_rx_buffer_tb_top;

    localparam int DEPTH = 32;
    localparam int NLBL  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_word = '0;
    logic        rx_valid = 1'b0;
    logic        recog_en = 1'b0;
    logic        remap_en = 1'b0;
    logic        lbl_load = 1'b0;
    logic        lbl_wr = 1'b0;
    logic [7:0]  lbl_data = '0;
    logic        rd_half = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic        data_ready;
    logic        half_full;
    logic        full;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] mq[$];
    logic [7:0]  m_code [NLBL];
    bit          m_valid [NLBL];
    int          m_ptr = 0;

    always #5 clk = ~clk;

    arinc_label_rx_buffer dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .recog_en   (recog_en),
        .remap_en   (remap_en),
        .lbl_load   (lbl_load),
        .lbl_wr     (lbl_wr),
        .lbl_data   (lbl_data),
        .rd_half    (rd_half),
        .rd_strobe  (rd_strobe),
        .rd_data    (rd_data),
        .data_ready (data_ready),
        .half_full  (half_full),
        .full       (full)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_flags(input string tag);
        int n;
        n = mq.size();
        check({tag, " data_ready"}, {31'd0, data_ready}, {31'd0, n >= 1});
        check({tag, " half_full"},  {31'd0, half_full},  {31'd0, n >= DEPTH / 2});
        check({tag, " full"},       {31'd0, full},       {31'd0, n == DEPTH});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        mq.delete();
        for (int i = 0; i < NLBL; i++) begin
            m_valid[i] = 1'b0;
            m_code[i]  = '0;
        end
        m_ptr = 0;
    endtask

    function automatic bit accepts(input logic [31:0] w);
        if (!recog_en) return 1'b1;
        for (int i = 0; i < NLBL; i++) begin
            if (m_valid[i] && m_code[i] == w[7:0]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic push_word(input logic [31:0] w);
        if (accepts(w) && mq.size() < DEPTH) mq.push_back(w);
        rx_word  = w;
        rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
        tick();
    endtask

    // R4: load mode restarts at entry 0 and wraps after 16 writes
    task automatic load_labels(input int n, input int mul, input int add);
        lbl_load = 1'b1;
        m_ptr = 0;
        tick();
        for (int i = 0; i < n; i++) begin
            lbl_data = 8'((i * mul + add) % 256);
            lbl_wr   = 1'b1;
            m_code[m_ptr]  = lbl_data;
            m_valid[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % NLBL;
            tick();
        end
        lbl_wr   = 1'b0;
        lbl_load = 1'b0;
        tick();
    endtask

    function automatic logic [31:0] image_of(input logic [31:0] w, input bit remap);
        logic [31:0] img;
        img = w;
        if (remap) begin
            for (int b = 0; b < 8; b++) img[b] = w[7 - b];
        end
        return img;
    endfunction

    // R5, R8, R9: two-transfer read of the head word
    task automatic read_one(input string tag);
        logic [31:0] exp_img;
        exp_img = image_of(mq[0], remap_en);
        rd_half = 1'b0;
        #1;
        check({tag, " R8 lower"}, {16'd0, rd_data}, {16'd0, exp_img[15:0]});
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        #1;
        check({tag, " R8 lower strobe keeps word"}, {16'd0, rd_data}, {16'd0, exp_img[15:0]});
        rd_half = 1'b1;
        #1;
        check({tag, " R8 upper"}, {16'd0, rd_data}, {16'd0, exp_img[31:16]});
        rd_strobe = 1'b1;
        void'(mq.pop_front());
        tick();
        rd_strobe = 1'b0;
        rd_half   = 1'b0;
        check_flags({tag, " R7 after pop"});
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) read_one(tag);
        check_flags({tag, " drained"});
    endtask

    task automatic sweep_labels();
        for (int l = 0; l < 256; l++) begin
            push_word({24'(l * 40503 + 7), 8'(l)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        check_flags("R1 reset state");

        // R2, R5, R6, R7: recognition off, fill past capacity
        recog_en = 1'b0;
        remap_en = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            push_word(32'h9E37_79B9 * (i + 1));
            check_flags("R7 fill");
        end
        check("R6 occupancy capped", mq.size(), DEPTH);
        check_flags("R6 full after drop");
        drain("R2 R5 R6 straight");

        // R10: pop strobe on empty buffer
        rd_half = 1'b1;
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        rd_half = 1'b0;
        tick();
        check("R10 empty after strobe", {31'd0, data_ready}, 32'd0);
        push_word(32'hC0DE_5A3C);
        check_flags("R10 one word");
        drain("R10 readback");

        // R1, R3, R4: three labels then a full label sweep, remapped
        do_reset();
        recog_en = 1'b1;
        load_labels(3, 165, 0);
        sweep_labels();
        check("R3 accepted three", mq.size(), 3);
        check_flags("R3 after sweep");
        remap_en = 1'b1;
        drain("R3 R9 remap");

        // R4: eighteen writes wrap over entries 0 and 1
        load_labels(18, 37, 11);
        sweep_labels();
        check("R4 accepted sixteen", mq.size(), 16);
        check_flags("R4 after wrap sweep");
        remap_en = 1'b0;
        drain("R4 straight");

        // R1: reset invalidates the table
        do_reset();
        recog_en = 1'b1;
        sweep_labels();
        check("R1 nothing accepted", {31'd0, data_ready}, 32'd0);
        check_flags("R1 after sweep");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule